// File: doc/BRIEF.md
# Functional Unit Reservation Tracker

This block guards the issue point of a small in-order dispatch stage against structural hazards. The stage owns five execution resources: two integer ALUs, one memory port and two floating-point units. Each cycle the dispatch logic presents one operation class code together with a valid bit. The tracker decides whether that class can start now, picks the unit that receives it, and keeps that unit marked busy for as many cycles as the class needs.

Every class has a fixed set of units it may use. Some classes have a preferred unit and a fallback unit. Some keep their unit occupied for a long time, such as divides and multi-cycle multiplies. One serialising class takes all five units at once. Along with the grant, the block outputs the result latency of the issued class, so that a downstream result-ready timer can be loaded in the same cycle.

The handshake on the class input is valid/ready. The ready output shows whether the presented class could issue this cycle. An issue happens only when valid and ready are both high.

Top module: `fu_rsv_tracker`

## Requirements
- R1: While reset is asserted and right after it, every unit is free. req_ready is high and, with req_valid low, unit_grant and result_lat are 0.
- R2: Class 0 (simple integer) goes to ALU 1 (grant bit 0) when ALU 1 is free, otherwise to ALU 2 (bit 1), with latency 1 and one busy cycle.
- R3: Class 1 (control transfer, conditional move, trap) may use only ALU 1 (bit 0). Class 2 (HI/LO transfer) may use only ALU 2 (bit 1). Both have latency 1 and one busy cycle.
- R4: Class 3 (pipelined multiply) takes ALU 2 for one busy cycle and reports latency 5. Class 4 (multiply, multiply-add) keeps ALU 2 busy for 7 cycles and reports latency 7.
- R5: Class 5 (32-bit divide) keeps ALU 2 busy for 12 cycles and class 6 (64-bit divide) for 25 cycles. Each reports a latency equal to its busy time.
- R6: Classes 7 (load), 8 (FP load / register-file transfer) and 9 (store, prefetch) use only the memory port (bit 2), for one busy cycle, with latencies 3, 4 and 0.
- R7: Class 10 (FP add, multiply, multiply-add) goes to FP unit 2 (bit 4) when it is free, otherwise to FP unit 1 (bit 3), with latency 6 and one busy cycle.
- R8: Class 11 (FP abs, compare, move, negate) uses only FP unit 1 with latency 2. Class 12 (FP convert) uses only FP unit 1 with latency 4. Both have one busy cycle.
- R9: Class 13 (single-precision FP divide or root) keeps FP unit 1 busy for 12 cycles and class 14 (double precision) for 19 cycles. The latency equals the busy time.
- R10: Class 15 (serialising) issues only when all five units are free. It then grants all five (unit_grant = 5'b11111) with latency 1 and one busy cycle on each.
- R11: When no eligible unit is free, req_ready is low, unit_grant and result_lat are 0, and no unit's remaining busy time changes.
- R12: A unit granted in cycle t with busy time N cannot be granted in cycles t+1 to t+N, and can be granted again from cycle t+N+1.
- R13: With req_valid low, unit_grant and result_lat are 0 and no unit is reserved, whatever class is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A class code is presented this cycle |
| req_class | input | 4 | Operation class code (0 to 15) |
| req_ready | output | 1 | The presented class could issue this cycle |
| unit_grant | output | 5 | Units reserved this cycle: bit 0 ALU 1, bit 1 ALU 2, bit 2 memory, bit 3 FP 1, bit 4 FP 2 |
| result_lat | output | 5 | Result latency of the issued class, 0 when nothing issues |

## Verification
Two things can coincide in one cycle: a unit's busy time running out, and a new request that needs exactly that unit. The same holds for a serialising request meeting the last busy unit as it frees. The bench keeps one request valid and retries it every cycle after a long-occupancy class, and it puts a load right before a serialising class. A model of per-unit free times, built from the requirements, predicts the exact cycle of the first grant. The bench also checks that every earlier attempt stalls without shifting that cycle.

// File: rtl/fu_rsv_pkg.sv
`timescale 1ns/1ps
package fu_rsv_pkg;

  localparam int unsigned NUM_UNITS = 5;
  localparam int unsigned CLS_W     = 4;
  localparam int unsigned LAT_W     = 5;
  localparam int unsigned MAX_OCC   = 25;
  localparam int unsigned OCC_W     = $clog2(MAX_OCC + 1);

  // unit index = grant bit position
  localparam int unsigned U_ALU1 = 0;
  localparam int unsigned U_ALU2 = 1;
  localparam int unsigned U_MEM  = 2;
  localparam int unsigned U_FP1  = 3;
  localparam int unsigned U_FP2  = 4;

  // busy times and latencies
  localparam int unsigned OCC_ONE     = 1;
  localparam int unsigned OCC_MUL     = 7;
  localparam int unsigned OCC_DIV32   = 12;
  localparam int unsigned OCC_DIV64   = 25;
  localparam int unsigned OCC_FDIV_S  = 12;
  localparam int unsigned OCC_FDIV_D  = 19;
  localparam int unsigned LAT_ONE     = 1;
  localparam int unsigned LAT_MUL3    = 5;
  localparam int unsigned LAT_LOAD    = 3;
  localparam int unsigned LAT_XFER    = 4;
  localparam int unsigned LAT_STORE   = 0;
  localparam int unsigned LAT_FARITH  = 6;
  localparam int unsigned LAT_FSIMPLE = 2;
  localparam int unsigned LAT_FCVT    = 4;

  typedef logic [NUM_UNITS-1:0] unit_mask_t;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT_SIMPLE = 4'd0,
    CLS_INT_CTRL   = 4'd1,
    CLS_INT_HILO   = 4'd2,
    CLS_INT_MUL3   = 4'd3,
    CLS_INT_MUL    = 4'd4,
    CLS_INT_DIV32  = 4'd5,
    CLS_INT_DIV64  = 4'd6,
    CLS_MEM_LOAD   = 4'd7,
    CLS_MEM_XFER   = 4'd8,
    CLS_MEM_STORE  = 4'd9,
    CLS_FP_ARITH   = 4'd10,
    CLS_FP_SIMPLE  = 4'd11,
    CLS_FP_CVT     = 4'd12,
    CLS_FP_DIV_S   = 4'd13,
    CLS_FP_DIV_D   = 4'd14,
    CLS_SERIAL     = 4'd15
  } op_class_e;

  typedef struct packed {
    unit_mask_t        pref;       // first-choice unit (at most one bit)
    unit_mask_t        alt;        // fallback unit (at most one bit)
    logic              all_units;  // needs every unit at once
    logic [OCC_W-1:0]  occ;        // busy cycles after issue
    logic [LAT_W-1:0]  lat;        // reported result latency
  } class_info_t;

endpackage

// File: rtl/fu_rst_sync.sv
`timescale 1ns/1ps
module fu_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;

endmodule

// File: rtl/fu_class_decode.sv
`timescale 1ns/1ps
module fu_class_decode
  import fu_rsv_pkg::*;
(
  input  op_class_e   cls,
  output class_info_t info
);

  function automatic unit_mask_t bit_of(input int unsigned idx);
    unit_mask_t m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  always_comb begin
    info           = '0;
    info.occ       = OCC_W'(OCC_ONE);
    info.lat       = LAT_W'(LAT_ONE);
    unique case (cls)
      CLS_INT_SIMPLE: begin
        info.pref = bit_of(U_ALU1);
        info.alt  = bit_of(U_ALU2);
      end
      CLS_INT_CTRL:   info.pref = bit_of(U_ALU1);
      CLS_INT_HILO:   info.pref = bit_of(U_ALU2);
      CLS_INT_MUL3: begin
        info.pref = bit_of(U_ALU2);
        info.lat  = LAT_W'(LAT_MUL3);
      end
      CLS_INT_MUL: begin
        info.pref = bit_of(U_ALU2);
        info.occ  = OCC_W'(OCC_MUL);
        info.lat  = LAT_W'(OCC_MUL);
      end
      CLS_INT_DIV32: begin
        info.pref = bit_of(U_ALU2);
        info.occ  = OCC_W'(OCC_DIV32);
        info.lat  = LAT_W'(OCC_DIV32);
      end
      CLS_INT_DIV64: begin
        info.pref = bit_of(U_ALU2);
        info.occ  = OCC_W'(OCC_DIV64);
        info.lat  = LAT_W'(OCC_DIV64);
      end
      CLS_MEM_LOAD: begin
        info.pref = bit_of(U_MEM);
        info.lat  = LAT_W'(LAT_LOAD);
      end
      CLS_MEM_XFER: begin
        info.pref = bit_of(U_MEM);
        info.lat  = LAT_W'(LAT_XFER);
      end
      CLS_MEM_STORE: begin
        info.pref = bit_of(U_MEM);
        info.lat  = LAT_W'(LAT_STORE);
      end
      CLS_FP_ARITH: begin
        info.pref = bit_of(U_FP2);
        info.alt  = bit_of(U_FP1);
        info.lat  = LAT_W'(LAT_FARITH);
      end
      CLS_FP_SIMPLE: begin
        info.pref = bit_of(U_FP1);
        info.lat  = LAT_W'(LAT_FSIMPLE);
      end
      CLS_FP_CVT: begin
        info.pref = bit_of(U_FP1);
        info.lat  = LAT_W'(LAT_FCVT);
      end
      CLS_FP_DIV_S: begin
        info.pref = bit_of(U_FP1);
        info.occ  = OCC_W'(OCC_FDIV_S);
        info.lat  = LAT_W'(OCC_FDIV_S);
      end
      CLS_FP_DIV_D: begin
        info.pref = bit_of(U_FP1);
        info.occ  = OCC_W'(OCC_FDIV_D);
        info.lat  = LAT_W'(OCC_FDIV_D);
      end
      CLS_SERIAL:     info.all_units = 1'b1;
      default: begin
        info = '0;
      end
    endcase
  end

endmodule

// File: rtl/fu_unit_timer.sv
`timescale 1ns/1ps
module fu_unit_timer #(
  parameter int unsigned OCC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OCC_W-1:0] occ,
  output logic             busy
);

  logic [OCC_W-1:0] cnt_q;
  logic [OCC_W-1:0] cnt_d;
  logic             cnt_en;

  // next state: a load starts a fresh busy window, otherwise count down
  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? occ : (cnt_q - OCC_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/fu_grant_select.sv
`timescale 1ns/1ps
module fu_grant_select
  import fu_rsv_pkg::*;
(
  input  class_info_t info,
  input  unit_mask_t  busy,
  output unit_mask_t  cand
);

  unit_mask_t free_units;

  always_comb begin
    free_units = ~busy;
    if (info.all_units) begin
      cand = (&free_units) ? '1 : '0;
    end else if ((info.pref & free_units) != '0) begin
      cand = info.pref & free_units;
    end else begin
      cand = info.alt & free_units;
    end
  end

endmodule

// File: rtl/fu_rsv_tracker.sv
`timescale 1ns/1ps
module fu_rsv_tracker
  import fu_rsv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CLS_W-1:0] req_class,
  output logic             req_ready,
  output logic [NUM_UNITS-1:0] unit_grant,
  output logic [LAT_W-1:0] result_lat
);

  logic        rst_sync_n;
  op_class_e   cls;
  class_info_t info;
  unit_mask_t  unit_busy;
  unit_mask_t  cand;
  logic        fire;

  fu_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  assign cls = op_class_e'(req_class);

  fu_class_decode u_decode (
    .cls  (cls),
    .info (info)
  );

  fu_grant_select u_select (
    .info (info),
    .busy (unit_busy),
    .cand (cand)
  );

  always_comb begin
    req_ready  = (cand != '0);
    fire       = req_valid & req_ready;
    unit_grant = fire ? cand : '0;
    result_lat = fire ? info.lat : '0;
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    fu_unit_timer #(
      .OCC_W (OCC_W)
    ) u_timer (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .load  (unit_grant[u]),
      .occ   (info.occ),
      .busy  (unit_busy[u])
    );
  end

endmodule

// File: rtl/fu_rsv_checker.sv
`timescale 1ns/1ps
module fu_rsv_checker
  import fu_rsv_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [CLS_W-1:0]     req_class,
  input logic                 req_ready,
  input logic [NUM_UNITS-1:0] unit_grant,
  input logic [LAT_W-1:0]     result_lat,
  input logic [NUM_UNITS-1:0] busy
);

  logic fire;
  logic fire_mul3;
  assign fire      = req_valid && req_ready;
  assign fire_mul3 = fire && (req_class == CLS_INT_MUL3);

  assert_grant_free_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_grant & busy) == '0);

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (unit_grant == '0) && (result_lat == '0));

  assert_stall_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> (unit_grant == '0));

  assert_serial_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_class == CLS_SERIAL) |-> (unit_grant == '1));

  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_class != CLS_SERIAL) |-> ($countones(unit_grant) == 1));

  assert_div_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_class == CLS_INT_DIV64) |=> busy[U_ALU2]);

  assert_fp_pref_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_class == CLS_FP_ARITH && !busy[U_FP2]) |-> unit_grant[U_FP2]);

  assert_mul3_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fire_mul3, 2) |-> !busy[U_ALU2]);

endmodule

bind fu_rsv_tracker fu_rsv_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_class  (req_class),
  .req_ready  (req_ready),
  .unit_grant (unit_grant),
  .result_lat (result_lat),
  .busy       (unit_busy)
);

// File: tb/fu_rsv_tracker_bench.sv
`timescale 1ns/1ps
module fu_rsv_tracker_bench;

  localparam logic [3:0] C_SIMPLE = 4'd0,  C_CTRL = 4'd1,  C_HILO = 4'd2,
                         C_MUL3   = 4'd3,  C_MUL  = 4'd4,  C_DIV32 = 4'd5,
                         C_DIV64  = 4'd6,  C_LOAD = 4'd7,  C_XFER = 4'd8,
                         C_STORE  = 4'd9,  C_FAR  = 4'd10, C_FSIM = 4'd11,
                         C_FCVT   = 4'd12, C_FDS  = 4'd13, C_FDD  = 4'd14,
                         C_SER    = 4'd15;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [3:0] req_class;
  logic       req_ready;
  logic [4:0] unit_grant;
  logic [4:0] result_lat;

  fu_rsv_tracker u_fu_rsv_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_class  (req_class),
    .req_ready  (req_ready),
    .unit_grant (unit_grant),
    .result_lat (result_lat)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  typedef struct {
    logic       ready;
    logic [4:0] grant;
    logic [4:0] lat;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;
  int   free_at[5];
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // class properties taken from the requirements
  task automatic lookup(input logic [3:0] c, output logic [4:0] pref,
                        output logic [4:0] alt, output bit all,
                        output int occ, output int lat, output string tag);
    pref = 5'b0; alt = 5'b0; all = 1'b0; occ = 1; lat = 1; tag = "";
    case (c)
      C_SIMPLE: begin pref = 5'b00001; alt = 5'b00010; tag = "R2"; end
      C_CTRL:   begin pref = 5'b00001; tag = "R3"; end
      C_HILO:   begin pref = 5'b00010; tag = "R3"; end
      C_MUL3:   begin pref = 5'b00010; lat = 5; tag = "R4"; end
      C_MUL:    begin pref = 5'b00010; occ = 7; lat = 7; tag = "R4"; end
      C_DIV32:  begin pref = 5'b00010; occ = 12; lat = 12; tag = "R5"; end
      C_DIV64:  begin pref = 5'b00010; occ = 25; lat = 25; tag = "R5"; end
      C_LOAD:   begin pref = 5'b00100; lat = 3; tag = "R6"; end
      C_XFER:   begin pref = 5'b00100; lat = 4; tag = "R6"; end
      C_STORE:  begin pref = 5'b00100; lat = 0; tag = "R6"; end
      C_FAR:    begin pref = 5'b10000; alt = 5'b01000; lat = 6; tag = "R7"; end
      C_FSIM:   begin pref = 5'b01000; lat = 2; tag = "R8"; end
      C_FCVT:   begin pref = 5'b01000; lat = 4; tag = "R8"; end
      C_FDS:    begin pref = 5'b01000; occ = 12; lat = 12; tag = "R9"; end
      C_FDD:    begin pref = 5'b01000; occ = 19; lat = 19; tag = "R9"; end
      default:  begin all = 1'b1; tag = "R10"; end
    endcase
  endtask

  // driver: predict, push expectation, drive for one cycle
  task automatic send(input bit v, input logic [3:0] c, output bit fired);
    logic [4:0] pref, alt, freem, cand;
    bit all;
    int occ, lat;
    string tag;
    exp_t e;
    lookup(c, pref, alt, all, occ, lat, tag);
    for (int u = 0; u < 5; u++) freem[u] = (cyc >= free_at[u]);
    if (all)                 cand = (freem == 5'h1F) ? 5'h1F : 5'h00;
    else if ((pref & freem) != 0) cand = pref & freem;
    else                     cand = alt & freem;
    fired = v && (cand != 0);
    if (fired)
      for (int u = 0; u < 5; u++) if (cand[u]) free_at[u] = cyc + occ + 1;
    e.ready = (cand != 0);
    e.grant = fired ? cand : 5'b0;
    e.lat   = fired ? 5'(lat) : 5'b0;
    if (!v)            e.tag = {"R13/", tag};
    else if (!e.ready) e.tag = {"R11/", tag};
    else if (occ > 1)  e.tag = {tag, "/R12"};
    else               e.tag = tag;
    sbq.push_back(e);
    req_valid = v;
    req_class = c;
    @(negedge clk);
    cyc++;
  endtask

  task automatic go(input logic [3:0] c);
    bit f;
    send(1'b1, c, f);
  endtask

  task automatic go_until(input logic [3:0] c);
    bit f;
    int n;
    n = 0;
    do begin
      send(1'b1, c, f);
      n++;
    end while (!f && n < 40);
  endtask

  task automatic idle(input int n);
    bit f;
    for (int i = 0; i < n; i++) send(1'b0, C_SIMPLE, f);
  endtask

  // monitor: pop and compare away from the clock edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #5;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        chk(req_ready == e.ready, e.tag, "ready", req_ready, e.ready);
        chk(unit_grant == e.grant, e.tag, "grant", unit_grant, e.grant);
        chk(result_lat == e.lat, e.tag, "latency", result_lat, e.lat);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit f;
    for (int u = 0; u < 5; u++) free_at[u] = 0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_class = C_SIMPLE;
    repeat (3) @(negedge clk);
    #5;
    // R1: reset state
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(unit_grant == 5'b0, "R1", "grant in reset", unit_grant, 0);
    chk(result_lat == 5'b0, "R1", "latency in reset", result_lat, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #5;
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    @(negedge clk);

    // R2: simple integer alternates when ALU 1 busy
    go(C_SIMPLE); go(C_SIMPLE); go(C_SIMPLE); go(C_SIMPLE);
    idle(2);
    // R3: control only ALU 1, second back-to-back stalls
    go(C_CTRL); go(C_CTRL); go(C_CTRL);
    go(C_SIMPLE); go(C_HILO); go(C_HILO);
    idle(2);
    // R4: pipelined multiply then long multiply
    go(C_MUL3); go(C_HILO); go(C_HILO);
    idle(2);
    go(C_MUL); go(C_SIMPLE); go(C_SIMPLE);
    go_until(C_HILO);
    idle(1);
    // R5 / R12: divides with retry right at release
    go(C_DIV32); go_until(C_HILO);
    idle(1);
    go(C_DIV64); go(C_MUL3); go(C_SIMPLE); go_until(C_MUL3);
    idle(1);
    // R6: memory port
    go(C_LOAD); go(C_XFER); go(C_XFER); go(C_STORE); go(C_STORE);
    idle(2);
    // R7: FP arith preference and fallback
    go(C_FAR); go(C_FAR); go(C_FAR);
    idle(2);
    go(C_FDS); go(C_FAR); go(C_FAR); go(C_FAR);
    go_until(C_FSIM);
    idle(1);
    // R8 / R9
    go(C_FSIM); go(C_FCVT); go(C_FCVT);
    idle(1);
    go(C_FDD); go(C_FCVT); go_until(C_FCVT);
    idle(2);
    // R10: serialising class
    go(C_SER); go(C_SER); go(C_SIMPLE);
    idle(1);
    go(C_LOAD); go(C_SER); go(C_SER);
    idle(1);
    go(C_DIV32); go_until(C_SER);
    idle(1);
    // R13: invalid request reserves nothing
    send(1'b0, C_DIV64, f); send(1'b0, C_SER, f);
    go(C_HILO); go(C_SER);
    idle(3);
    wait (sbq.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule